// File: doc/BRIEF.md
# Watchdog and Reset-Source Controller

This block supervises software with a watchdog and merges every reset source into one active-low reset pulse. It picks one of three watchdog behaviours from the operating-mode code, a mode-select bit and a disable pin. In Window behaviour, a service strobe that arrives too early forces a reset, and so does a missed service. In Timeout behaviour, the first missed service raises a cyclic interrupt flag. The second one, if software has not cleared that flag, forces a reset. In Off behaviour the watchdog does nothing.

Other reset sources are also accepted: a supply undervoltage, the external reset pin read low, a software reset strobe, leaving overtemperature, and any change of the watchdog configuration. When one or more sources are active, the controller drives a reset pulse of fixed length and latches a 3-bit cause code. The code keeps its value until the next pulse.

The timer is a state machine with four states:
- `T_OFF`: the watchdog is idle.
- `T_WIN_CLOSED`: Window behaviour, first half of the period. A service strobe here is too early.
- `T_WIN_OPEN`: Window behaviour, second half of the period. A service strobe here is accepted.
- `T_TIMEOUT`: Timeout behaviour, counting.

The timer transitions are:
- **enter**: to the entry state of the requested behaviour, whenever the timer's state does not match that behaviour or a reset pulse is in progress.
- **open**: from `T_WIN_CLOSED` to `T_WIN_OPEN`, when the tick count reaches half the period.
- **restart**: back to the entry state with the count cleared, on an accepted service strobe or on an overflow.

The pulse sequencer is a state machine with three states:
- `P_IDLE`: watching the reset sources.
- `P_ASSERT`: the reset output is held low.
- `P_RECOVER`: one release cycle.

Its transitions are:
- **fire**: `P_IDLE` to `P_ASSERT`, when any source is active.
- **release**: `P_ASSERT` to `P_RECOVER`, when the pulse length has elapsed.
- **rearm**: `P_RECOVER` to `P_IDLE`.

Top module: `wdg_rst_ctrl`

## Requirements
- R1: Watchdog behaviour is decoded from the operating-mode code (0 Normal, 1 Standby, 2 Sleep, 3 Overtemp, 4 and above Off). Window behaviour applies in Normal with the select bit 0 and the disable pin low. Timeout behaviour applies in Normal or Standby with the select bit 1 and the disable pin low. Every other combination, including the disable pin high, is Off.
- R2: The period is P = 4 x (period_sel + 1) ticks, and one tick is 2 clocks. After a restart with no service strobe, a Window-behaviour overflow drives the reset output low right after the 2P-th clock edge, with cause code 5.
- R3: In Window behaviour, a service strobe sampled while fewer than P/2 ticks have elapsed starts a reset with cause code 6.
- R4: In Window behaviour, a service strobe sampled once P/2 or more ticks have elapsed restarts the period without any reset.
- R5: In Timeout behaviour, a service strobe at any moment restarts the period. An overflow while the interrupt flag is clear sets the flag and restarts the period without any reset.
- R6: A Timeout-behaviour overflow while the flag is set starts a reset with cause code 5. If the clear strobe is sampled on the same clock as that overflow, the flag stays set and no reset starts.
- R7: A clear strobe clears the interrupt flag on the next edge. Every reset pulse also clears the flag.
- R8: While the watchdog is Off, service strobes have no effect and no watchdog reset or interrupt occurs. Leaving Off starts a fresh period from zero.
- R9: The remaining sources have these cause codes: undervoltage 1, external pin low 2, software strobe 3, overtemperature exit 4. Each one drives the reset output low right after the edge that samples it.
- R10: A change of the disable pin in any mode, or of the select bit while in Normal, starts a reset with cause code 7. A change of the select bit outside Normal does not start a reset.
- R11: The reset output stays low for exactly 4 clocks when long_pulse is 0 and for exactly 12 clocks when it is 1.
- R12: When several sources are active on the same clock, the lowest cause code is latched. The cause holds until the next pulse. Sources are ignored during the pulse and for one recovery clock after it.
- R13: During and right after power-on reset, the reset output is high, the flag is 0 and the cause code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| op_mode | input | 3 | Operating-mode code |
| mode_bit | input | 1 | Watchdog select bit (0 window, 1 timeout) |
| wd_disable | input | 1 | Watchdog disable pin level |
| period_sel | input | 4 | Period code |
| long_pulse | input | 1 | Selects the long reset pulse |
| trig | input | 1 | Watchdog service strobe |
| sw_reset | input | 1 | Software reset strobe |
| int_clr | input | 1 | Interrupt flag clear strobe |
| uv_flag | input | 1 | Supply undervoltage |
| ot_exit | input | 1 | Overtemperature exit event |
| ext_rst_n_in | input | 1 | Level read back from the reset pin |
| rst_n_out | output | 1 | Reset request, active low |
| cyc_int | output | 1 | Cyclic interrupt flag |
| rst_cause | output | 3 | Latched cause of the last reset |

## Verification
The clear strobe and a Timeout overflow can fall on the same clock edge. The bench first lets a Timeout overflow set the flag. It then pulses the clear strobe so that it is sampled on exactly the edge of the second overflow. It expects the reset output to stay high and the flag to remain set after that edge. It then expects a reset with cause 5 on the following overflow, exactly 2P edges later. Coinciding sources (undervoltage with the external pin, software reset with overtemperature exit) are judged by the latched cause code.

// File: rtl/wdg_rst_pkg.sv
package wdg_rst_pkg;

    localparam logic [2:0] OPM_NORMAL   = 3'd0;
    localparam logic [2:0] OPM_STANDBY  = 3'd1;
    localparam logic [2:0] OPM_SLEEP    = 3'd2;
    localparam logic [2:0] OPM_OVERTEMP = 3'd3;

    localparam int NUM_CAUSE = 7;

    localparam logic [2:0] CAUSE_NONE  = 3'd0;
    localparam logic [2:0] CAUSE_UV    = 3'd1;
    localparam logic [2:0] CAUSE_EXT   = 3'd2;
    localparam logic [2:0] CAUSE_SW    = 3'd3;
    localparam logic [2:0] CAUSE_OTX   = 3'd4;
    localparam logic [2:0] CAUSE_OVF   = 3'd5;
    localparam logic [2:0] CAUSE_EARLY = 3'd6;
    localparam logic [2:0] CAUSE_CFG   = 3'd7;

    typedef enum logic [1:0] {
        WM_OFF     = 2'd0,
        WM_WINDOW  = 2'd1,
        WM_TIMEOUT = 2'd2
    } wd_mode_e;

    typedef enum logic [1:0] {
        T_OFF        = 2'd0,
        T_WIN_CLOSED = 2'd1,
        T_WIN_OPEN   = 2'd2,
        T_TIMEOUT    = 2'd3
    } tmr_state_e;

    typedef enum logic [1:0] {
        P_IDLE    = 2'd0,
        P_ASSERT  = 2'd1,
        P_RECOVER = 2'd2
    } pulse_state_e;

endpackage

// File: rtl/wdg_mode_dec.sv
module wdg_mode_dec
    import wdg_rst_pkg::*;
(
    input  logic [2:0] op_mode,
    input  logic       mode_bit,
    input  logic       wd_disable,
    output wd_mode_e   wmode
);

    always_comb begin
        wmode = WM_OFF;
        if (!wd_disable) begin
            unique case (op_mode)
                OPM_NORMAL:  wmode = mode_bit ? WM_TIMEOUT : WM_WINDOW;
                OPM_STANDBY: wmode = mode_bit ? WM_TIMEOUT : WM_OFF;
                default:     wmode = WM_OFF;
            endcase
        end
    end

endmodule

// File: rtl/wdg_cfg_watch.sv
module wdg_cfg_watch
    import wdg_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_mode,
    input  logic       mode_bit,
    input  logic       wd_disable,
    output logic       cfg_rst
);

    logic primed_q;
    logic mb_q;
    logic dis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            mb_q     <= 1'b0;
            dis_q    <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            mb_q     <= mode_bit;
            dis_q    <= wd_disable;
        end
    end

    always_comb begin
        cfg_rst = 1'b0;
        if (primed_q) begin
            if (wd_disable != dis_q)
                cfg_rst = 1'b1;
            if ((op_mode == OPM_NORMAL) && (mode_bit != mb_q))
                cfg_rst = 1'b1;
        end
    end

    // R10: once primed, a flip of the disable pin is always reported
    p_dis_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $changed(wd_disable)) |-> cfg_rst);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_rst_pkg::*;
#(
    parameter int TICK_DIV = 2,
    parameter int PER_BASE = 4,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_mode_e         req_mode,
    input  logic             hold,
    input  logic             trig,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             int_clr,
    output logic             ovf_rst,
    output logic             early_rst,
    output logic             cyc_int
);

    localparam int MAX_TICKS = PER_BASE * (1 << SEL_W);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             ci_q, ci_d;

    logic [CNT_W-1:0] period_ticks;
    logic [CNT_W-1:0] half_ticks;
    logic             tick;
    logic             at_top;
    logic             in_mode;
    logic             active;
    logic             to_ovf;

    function automatic wd_mode_e class_of(input tmr_state_e s);
        unique case (s)
            T_WIN_CLOSED, T_WIN_OPEN: class_of = WM_WINDOW;
            T_TIMEOUT:                class_of = WM_TIMEOUT;
            default:                  class_of = WM_OFF;
        endcase
    endfunction

    function automatic tmr_state_e entry_of(input wd_mode_e m);
        unique case (m)
            WM_WINDOW:  entry_of = T_WIN_CLOSED;
            WM_TIMEOUT: entry_of = T_TIMEOUT;
            default:    entry_of = T_OFF;
        endcase
    endfunction

    assign period_ticks = CNT_W'(PER_BASE) * (CNT_W'(period_sel) + CNT_W'(1));
    assign half_ticks   = period_ticks >> 1;
    assign tick         = (pre_q == PRE_W'(TICK_DIV - 1));
    assign at_top       = tick && (cnt_q == period_ticks - CNT_W'(1));
    assign in_mode      = (class_of(state_q) == req_mode);
    assign active       = in_mode && !hold && (state_q != T_OFF);

    // Events seen by the pulse sequencer
    always_comb begin
        early_rst = active && (state_q == T_WIN_CLOSED) && trig;
        to_ovf    = active && (state_q == T_TIMEOUT) && at_top && !trig;
        ovf_rst   = (active && (state_q == T_WIN_OPEN) && at_top && !trig)
                  || (to_ovf && ci_q && !int_clr);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_OFF;
            cnt_q   <= '0;
            pre_q   <= '0;
            ci_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pre_q   <= pre_d;
            ci_q    <= ci_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pre_d   = tick ? '0 : pre_q + PRE_W'(1);
        if (hold || !in_mode) begin
            state_d = entry_of(req_mode);
            cnt_d   = '0;
            pre_d   = '0;
        end else begin
            unique case (state_q)
                T_OFF: begin
                    cnt_d = '0;
                    pre_d = '0;
                end
                T_WIN_CLOSED: begin
                    if (trig) begin
                        cnt_d = '0;
                        pre_d = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) >= half_ticks)
                            state_d = T_WIN_OPEN;
                    end
                end
                T_WIN_OPEN: begin
                    if (trig || at_top) begin
                        state_d = T_WIN_CLOSED;
                        cnt_d   = '0;
                        pre_d   = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                T_TIMEOUT: begin
                    if (trig || at_top) begin
                        cnt_d = '0;
                        pre_d = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_d = T_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Interrupt flag: a clear meeting an overflow lets the set win
    always_comb begin
        ci_d = ci_q;
        if (hold)
            ci_d = 1'b0;
        else if (to_ovf && (!ci_q || int_clr))
            ci_d = 1'b1;
        else if (int_clr)
            ci_d = 1'b0;
    end

    assign cyc_int = ci_q;

    // R5: first timeout overflow raises the flag
    p_ci_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_ovf && !ci_q && !hold) |=> ci_q);

    // R7: the flag only drops after a clear strobe or a reset pulse
    p_ci_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ci_q) |-> $past(int_clr || hold));

    // R6: clear coinciding with an overflow never yields a reset
    p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (to_ovf && int_clr) |-> !ovf_rst);

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq
    import wdg_rst_pkg::*;
#(
    parameter int RST_SHORT = 4,
    parameter int RST_LONG  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] causes,
    input  logic                 long_pulse,
    output logic                 rst_n_out,
    output logic                 hold,
    output logic [2:0]           rst_cause
);

    localparam int LEN_MAX = (RST_LONG > RST_SHORT) ? RST_LONG : RST_SHORT;
    localparam int LEN_W   = $clog2(LEN_MAX + 1);

    pulse_state_e     state_q, state_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] len_sel;
    logic [2:0]       cause_q, cause_d;
    logic [2:0]       win_code;

    assign len_sel = long_pulse ? LEN_W'(RST_LONG) : LEN_W'(RST_SHORT);

    // Lowest code wins
    always_comb begin
        win_code = CAUSE_NONE;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (causes[i])
                win_code = 3'(i + 1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            len_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            cause_q <= cause_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        cause_d = cause_q;
        unique case (state_q)
            P_IDLE: begin
                if (win_code != CAUSE_NONE) begin
                    state_d = P_ASSERT;
                    len_d   = '0;
                    cause_d = win_code;
                end
            end
            P_ASSERT: begin
                if (len_q == len_sel - LEN_W'(1))
                    state_d = P_RECOVER;
                else
                    len_d = len_q + LEN_W'(1);
            end
            P_RECOVER: state_d = P_IDLE;
            default:   state_d = P_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rst_n_out = 1'b1;
        hold      = 1'b1;
        unique case (state_q)
            P_IDLE:    hold = 1'b0;
            P_ASSERT:  rst_n_out = 1'b0;
            P_RECOVER: hold = 1'b1;
            default:   hold = 1'b1;
        endcase
    end

    assign rst_cause = cause_q;

    // R12: every pulse carries a cause
    p_cause_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_out) |-> (rst_cause != CAUSE_NONE));

    // R12: cause frozen while a pulse is in flight
    p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != P_IDLE) |=> $stable(rst_cause));

    // R11: no pulse shorter than two clocks
    p_min_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_out) |=> !rst_n_out);

endmodule

// File: rtl/wdg_rst_ctrl.sv
module wdg_rst_ctrl
    import wdg_rst_pkg::*;
#(
    parameter int TICK_DIV  = 2,
    parameter int PER_BASE  = 4,
    parameter int SEL_W     = 4,
    parameter int RST_SHORT = 4,
    parameter int RST_LONG  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_mode,
    input  logic             mode_bit,
    input  logic             wd_disable,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             long_pulse,
    input  logic             trig,
    input  logic             sw_reset,
    input  logic             int_clr,
    input  logic             uv_flag,
    input  logic             ot_exit,
    input  logic             ext_rst_n_in,
    output logic             rst_n_out,
    output logic             cyc_int,
    output logic [2:0]       rst_cause
);

    wd_mode_e             wmode;
    logic                 cfg_rst;
    logic                 ev_ovf;
    logic                 ev_early;
    logic                 hold;
    logic [NUM_CAUSE-1:0] causes;

    wdg_mode_dec u_dec (
        .op_mode    (op_mode),
        .mode_bit   (mode_bit),
        .wd_disable (wd_disable),
        .wmode      (wmode)
    );

    wdg_cfg_watch u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_mode    (op_mode),
        .mode_bit   (mode_bit),
        .wd_disable (wd_disable),
        .cfg_rst    (cfg_rst)
    );

    wdg_timer #(
        .TICK_DIV (TICK_DIV),
        .PER_BASE (PER_BASE),
        .SEL_W    (SEL_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_mode   (wmode),
        .hold       (hold),
        .trig       (trig),
        .period_sel (period_sel),
        .int_clr    (int_clr),
        .ovf_rst    (ev_ovf),
        .early_rst  (ev_early),
        .cyc_int    (cyc_int)
    );

    // bit i carries cause code i+1
    assign causes = {cfg_rst, ev_early, ev_ovf, ot_exit,
                     sw_reset, !ext_rst_n_in, uv_flag};

    rst_pulse_seq #(
        .RST_SHORT (RST_SHORT),
        .RST_LONG  (RST_LONG)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .causes     (causes),
        .long_pulse (long_pulse),
        .rst_n_out  (rst_n_out),
        .hold       (hold),
        .rst_cause  (rst_cause)
    );

    // R8: an Off watchdog raises no watchdog event
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wmode == WM_OFF) |-> !(ev_ovf || ev_early));

    // R10: a configuration change seen while idle yields a pulse
    p_cfg_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rst && !hold) |=> !rst_n_out);

endmodule

// File: tb/wdg_rst_ctrl_bench.sv
module wdg_rst_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_mode = 3'd0;
    logic       mode_bit = 1'b0;
    logic       wd_disable = 1'b0;
    logic [3:0] period_sel = 4'd0;
    logic       long_pulse = 1'b0;
    logic       trig = 1'b0;
    logic       sw_reset = 1'b0;
    logic       int_clr = 1'b0;
    logic       uv_flag = 1'b0;
    logic       ot_exit = 1'b0;
    logic       ext_rst_n_in = 1'b1;
    logic       rst_n_out;
    logic       cyc_int;
    logic [2:0] rst_cause;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdg_rst_ctrl u_wdg_rst_ctrl (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .mode_bit(mode_bit),
        .wd_disable(wd_disable), .period_sel(period_sel), .long_pulse(long_pulse),
        .trig(trig), .sw_reset(sw_reset), .int_clr(int_clr), .uv_flag(uv_flag),
        .ot_exit(ot_exit), .ext_rst_n_in(ext_rst_n_in), .rst_n_out(rst_n_out),
        .cyc_int(cyc_int), .rst_cause(rst_cause)
    );

    typedef struct packed {
        logic       mb;
        logic [3:0] sel;
        logic [7:0] trig_at;
        logic [7:0] obs;
        logic       low;
        logic [2:0] cause;
        logic       ci;
    } vec_t;

    // window: mb=0, timeout: mb=1, Normal mode; P = 4*(sel+1)
    localparam vec_t VEC [14] = '{
        '{1'b0, 4'd0, 8'd0,  8'd9,  1'b1, 3'd5, 1'b0},
        '{1'b0, 4'd0, 8'd0,  8'd8,  1'b0, 3'd0, 1'b0},
        '{1'b0, 4'd0, 8'd2,  8'd9,  1'b1, 3'd6, 1'b0},
        '{1'b0, 4'd0, 8'd6,  8'd14, 1'b0, 3'd0, 1'b0},
        '{1'b0, 4'd1, 8'd12, 8'd28, 1'b0, 3'd0, 1'b0},
        '{1'b0, 4'd1, 8'd8,  8'd12, 1'b1, 3'd6, 1'b0},
        '{1'b0, 4'd1, 8'd9,  8'd25, 1'b0, 3'd0, 1'b0},
        '{1'b1, 4'd0, 8'd0,  8'd12, 1'b0, 3'd0, 1'b1},
        '{1'b1, 4'd0, 8'd0,  8'd20, 1'b1, 3'd5, 1'b0},
        '{1'b1, 4'd0, 8'd2,  8'd12, 1'b0, 3'd0, 1'b1},
        '{1'b1, 4'd0, 8'd2,  8'd10, 1'b0, 3'd0, 1'b0},
        '{1'b1, 4'd2, 8'd20, 8'd30, 1'b0, 3'd0, 1'b0},
        '{1'b0, 4'd3, 8'd0,  8'd33, 1'b1, 3'd5, 1'b0},
        '{1'b0, 4'd3, 8'd0,  8'd32, 1'b0, 3'd0, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic por();
        rst_n = 1'b0;
        trig = 1'b0; sw_reset = 1'b0; int_clr = 1'b0;
        uv_flag = 1'b0; ot_exit = 1'b0; ext_rst_n_in = 1'b1;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int e = 0; e < n; e++) begin
            step(1);
            if (!rst_n_out) lows++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int lows;
        int seen;
        int cz;

        // R13: reset state
        op_mode = 3'd2;
        rst_n = 1'b0;
        step(2);
        chk("R13 rst_n_out in reset", rst_n_out, 1);
        chk("R13 cyc_int in reset", cyc_int, 0);
        chk("R13 cause in reset", rst_cause, 0);
        rst_n = 1'b1;
        step(2);
        chk("R13 rst_n_out after reset", rst_n_out, 1);
        chk("R13 cause after reset", rst_cause, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 14; v++) begin
            op_mode = 3'd0;
            mode_bit = VEC[v].mb;
            period_sel = VEC[v].sel;
            long_pulse = 1'b0;
            wd_disable = 1'b0;
            por();
            seen = 0;
            cz = 0;
            for (int e = 1; e <= int'(VEC[v].obs); e++) begin
                step(1);
                trig = (e == int'(VEC[v].trig_at));
                if (!rst_n_out && seen == 0) begin
                    seen = 1;
                    cz = rst_cause;
                end
            end
            trig = 1'b0;
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d reset seen", v), seen, VEC[v].low);
            if (VEC[v].low)
                chk($sformatf("R2/R3/R6 vec%0d cause", v), cz, VEC[v].cause);
            chk($sformatf("R5/R7 vec%0d cyc_int", v), cyc_int, VEC[v].ci);
        end

        // R1: Sleep is Off, triggers ignored (R8)
        op_mode = 3'd2; mode_bit = 1'b1; period_sel = 4'd0;
        por();
        lows = 0;
        for (int k = 0; k < 40; k++) begin
            step(1);
            trig = (k % 3 == 0);
            if (!rst_n_out) lows++;
        end
        trig = 1'b0;
        chk("R1 R8 sleep no reset", lows, 0);
        chk("R8 sleep no interrupt", cyc_int, 0);

        // R1: Standby with bit 0 is Off
        op_mode = 3'd1; mode_bit = 1'b0;
        por();
        count_low(40, lows);
        chk("R1 standby bit0 off", lows, 0);

        // R1: disable pin high in Normal is Off
        op_mode = 3'd0; mode_bit = 1'b0; wd_disable = 1'b1;
        por();
        count_low(40, lows);
        chk("R1 disable high off", lows, 0);
        wd_disable = 1'b0;
        por();

        // R1: Standby with bit 1 is Timeout, flag at edge 9
        op_mode = 3'd1; mode_bit = 1'b1;
        por();
        step(8);
        chk("R1 standby timeout flag before", cyc_int, 0);
        step(1);
        chk("R1 standby timeout flag set", cyc_int, 1);
        chk("R1 standby timeout no reset", rst_n_out, 1);

        // R8: Off clears the count
        op_mode = 3'd0; mode_bit = 1'b1;
        por();
        step(6);
        op_mode = 3'd2;
        step(2);
        trig = 1'b1;
        step(1);
        trig = 1'b0;
        step(2);
        op_mode = 3'd0;
        step(8);
        chk("R8 fresh period flag before", cyc_int, 0);
        step(1);
        chk("R8 fresh period flag set", cyc_int, 1);

        // R7: clear strobe
        por();
        step(9);
        chk("R7 flag set", cyc_int, 1);
        int_clr = 1'b1;
        step(1);
        int_clr = 1'b0;
        chk("R7 flag cleared", cyc_int, 0);

        // R6: clear on the overflow edge
        por();
        step(16);
        int_clr = 1'b1;
        step(1);
        int_clr = 1'b0;
        chk("R6 coincident no reset", rst_n_out, 1);
        chk("R6 coincident flag kept", cyc_int, 1);
        step(7);
        chk("R6 before next overflow", rst_n_out, 1);
        step(1);
        chk("R6 overflow with flag", rst_n_out, 0);
        chk("R6 overflow cause", rst_cause, 5);

        // R9 R11: software reset, short then long
        op_mode = 3'd2; mode_bit = 1'b0;
        por();
        step(3);
        sw_reset = 1'b1;
        step(1);
        sw_reset = 1'b0;
        chk("R9 sw low", rst_n_out, 0);
        chk("R9 sw cause", rst_cause, 3);
        step(3);
        chk("R11 short still low", rst_n_out, 0);
        step(1);
        chk("R11 short released", rst_n_out, 1);
        long_pulse = 1'b1;
        por();
        step(3);
        sw_reset = 1'b1;
        step(1);
        sw_reset = 1'b0;
        step(11);
        chk("R11 long still low", rst_n_out, 0);
        step(1);
        chk("R11 long released", rst_n_out, 1);
        long_pulse = 1'b0;

        // R12: priorities
        por();
        step(3);
        uv_flag = 1'b1; ext_rst_n_in = 1'b0;
        step(1);
        uv_flag = 1'b0; ext_rst_n_in = 1'b1;
        chk("R12 uv over ext", rst_cause, 1);
        por();
        step(3);
        ext_rst_n_in = 1'b0;
        step(1);
        ext_rst_n_in = 1'b1;
        chk("R9 ext cause", rst_cause, 2);
        por();
        step(3);
        ot_exit = 1'b1;
        step(1);
        ot_exit = 1'b0;
        chk("R9 overtemp exit cause", rst_cause, 4);
        por();
        step(3);
        sw_reset = 1'b1; ot_exit = 1'b1;
        step(1);
        sw_reset = 1'b0; ot_exit = 1'b0;
        chk("R12 sw over otx", rst_cause, 3);

        // R12: sources ignored during pulse and recovery
        por();
        step(3);
        sw_reset = 1'b1;
        step(1);
        sw_reset = 1'b0;
        step(1);
        uv_flag = 1'b1;
        step(1);
        uv_flag = 1'b0;
        step(2);
        chk("R12 pulse length unchanged", rst_n_out, 1);
        uv_flag = 1'b1;
        step(1);
        uv_flag = 1'b0;
        chk("R12 recovery ignores source", rst_n_out, 1);
        chk("R12 cause kept", rst_cause, 3);
        count_low(6, lows);
        chk("R12 no late pulse", lows, 0);

        // R10: configuration changes
        por();
        step(3);
        wd_disable = 1'b1;
        step(1);
        chk("R10 disable flip reset", rst_n_out, 0);
        chk("R10 disable flip cause", rst_cause, 7);
        wd_disable = 1'b0;
        por();
        op_mode = 3'd0; mode_bit = 1'b0; period_sel = 4'd3;
        por();
        step(3);
        mode_bit = 1'b1;
        step(1);
        chk("R10 bit flip in Normal", rst_n_out, 0);
        chk("R10 bit flip cause", rst_cause, 7);
        op_mode = 3'd1; mode_bit = 1'b1;
        por();
        step(3);
        mode_bit = 1'b0;
        count_low(20, lows);
        chk("R10 bit flip in Standby ignored", lows, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule